// File: doc/BRIEF.md
# Cursor Register Arming Unit

This block keeps two copies of the four registers that describe a display cursor plane. The first copy takes software writes from a single-cycle register bus. The second copy drives the display pipeline. Software fills the pending copy and then arms a transfer. The transfer moves every pending register into the active copy at the next rising edge of the vertical-blank input. This lets the visible cursor change shape, position and surface between frames, and never partway through one.

Only a surface-address write arms a transfer. A control write that turns the plane on from an off state also arms one. Every other register write withdraws a transfer that is armed but has not yet taken place. For this reason software writes the position first and the surface address last. A status output shows whether a transfer is still waiting, so software can poll it to learn when an update has completed. The active mode field drives a plane-on indication.

Register map, as seen on both `bus_addr` and `rd_addr`:

| Address | Register |
|---|---|
| 0 | control |
| 1 | position |
| 2 | surface base |
| 3 | partial height |

Top module: `curs_shadow`

## Requirements
- R1: After reset, every active register, every pending register (read through `rd_data`), `armed` and `plane_on` are zero.
- R2: A write to address n (0 control, 1 position, 2 base, 3 partial height) updates the pending register n. That value is readable on `rd_data` one cycle later. The active registers do not change because of the write.
- R3: A write to address 2 (base) sets `armed` from the next cycle on. This holds even when a transfer was already armed.
- R4: At the first clock edge where `vblank` is sampled high after being sampled low, with `armed` set, all four active registers take the pending values that were held before that edge. `armed` clears at that same edge.
- R5: With `armed` clear, a rising `vblank` changes no active register. A `vblank` held high causes at most one transfer, and only at its rising edge.
- R6: A write to address 1 or 3 clears `armed` from the next cycle on. The transfer it withdrew does not happen at the following `vblank` rise.
- R7: A control write whose mode field (bits MODE_W-1:0, default 2:0) is non-zero arms the transfer if the active mode field is zero at that moment. Any other control write clears `armed`.
- R8: A position write never arms a transfer. The new position reaches the active copy only after a following base write and a `vblank` rise.
- R9: The partial-height register keeps only its enable bit (bit DW-1, bit 31 by default) and its height-minus-one field (bits HGT_W-1:0, bits 9:0 by default). All other bits read as zero in both copies.
- R10: `plane_on` is 1 exactly when the active control mode field is non-zero.
- R11: A write in the same cycle as a transfer edge does not alter what is transferred. Afterwards `armed` is 1 if the write arms a transfer and 0 otherwise. When a write both arms and withdraws, arming wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register write address |
| bus_wdata | input | DW | Register write data |
| rd_addr | input | 2 | Pending-copy read address |
| rd_data | output | DW | Pending register selected by `rd_addr` |
| vblank | input | 1 | Vertical-blank level; its rising edge latches an armed update |
| act_ctrl | output | DW | Active control register |
| act_pos | output | DW | Active position register |
| act_base | output | DW | Active surface base register |
| act_phgt | output | DW | Active partial-height register |
| plane_on | output | 1 | Active mode field is non-zero |
| armed | output | 1 | An update is armed and waiting for vertical blank |

## Verification
The bench runs directed sequences first:
- position-only writes followed by `vblank`, which separate a design that arms on any write from one that arms only on the base register;
- arm-then-position writes, which expose a missing cancel;
- enable writes with the plane off and then on, which tell the disabled-to-enabled arming apart from plain control writes;
- a `vblank` held high across a fresh arm, which separates edge triggering from level triggering.

A write that lands on the transfer edge checks that the transferred values are the ones from before the write and that arming wins. Seeded random mixes of writes, reads and `vblank` levels are then compared every cycle against a reference model in the bench.

// File: rtl/curs_shadow_pkg.sv
package curs_shadow_pkg;
   localparam int unsigned NUM_CSR = 4;
   localparam int unsigned CSR_AW  = 2;

   typedef enum logic [CSR_AW-1:0] {
      CSR_CTRL = 2'd0,
      CSR_POS  = 2'd1,
      CSR_BASE = 2'd2,
      CSR_PHGT = 2'd3
   } csr_sel_e;
endpackage

// File: rtl/curs_regbank.sv
// One copy of the cursor registers; each register loads under its own strobe.
module curs_regbank
   import curs_shadow_pkg::*;
#(
   parameter int unsigned DW    = 32,
   parameter int unsigned HGT_W = 10
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [NUM_CSR-1:0]            ld,
   input  logic [NUM_CSR-1:0][DW-1:0]    din,
   output logic [NUM_CSR-1:0][DW-1:0]    q
);
   // enable bit on top, height-minus-one in the low field
   localparam logic [DW-1:0] PH_MASK =
      {1'b1, {(DW-1-HGT_W){1'b0}}, {HGT_W{1'b1}}};

   generate
      for (genvar i = 0; i < NUM_CSR; i++) begin : g_reg
         localparam logic [DW-1:0] MSK =
            (i == int'(CSR_PHGT)) ? PH_MASK : {DW{1'b1}};
         logic [DW-1:0] r;
         always_ff @(posedge clk) begin
            if (!rst_n)      r <= '0;
            else if (ld[i])  r <= din[i] & MSK;
         end
         assign q[i] = r;
      end
   endgenerate
endmodule

// File: rtl/curs_armctl.sv
// Arm / cancel decision and vertical-blank edge detection.
module curs_armctl
   import curs_shadow_pkg::*;
#(
   parameter int unsigned MODE_W  = 3,
   parameter bit          VB_SYNC = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [CSR_AW-1:0] addr,
   input  logic [MODE_W-1:0] wr_mode,
   input  logic              act_live,
   input  logic              vblank,
   output logic              armed,
   output logic              xfer
);
   logic vb_in, vb_q, vb_rise;
   logic arm_req, cancel_req, armed_q;

   generate
      if (VB_SYNC) begin : g_vsync
         logic s1, s2;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               s1 <= 1'b0;
               s2 <= 1'b0;
            end else begin
               s1 <= vblank;
               s2 <= s1;
            end
         end
         assign vb_in = s2;
      end else begin : g_vdirect
         assign vb_in = vblank;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) vb_q <= 1'b0;
      else        vb_q <= vb_in;
   end
   assign vb_rise = vb_in & ~vb_q;

   // base write always arms; enable write arms only when plane is off
   always_comb begin
      arm_req = 1'b0;
      if (wr) begin
         if (addr == CSR_BASE)
            arm_req = 1'b1;
         else if (addr == CSR_CTRL && (|wr_mode) && !act_live)
            arm_req = 1'b1;
      end
      cancel_req = wr & ~arm_req;
   end

   assign xfer = vb_rise & armed_q;

   always_ff @(posedge clk) begin
      if (!rst_n)           armed_q <= 1'b0;
      else if (arm_req)     armed_q <= 1'b1;
      else if (cancel_req)  armed_q <= 1'b0;
      else if (xfer)        armed_q <= 1'b0;
   end
   assign armed = armed_q;
endmodule

// File: rtl/curs_shadow.sv
module curs_shadow
   import curs_shadow_pkg::*;
#(
   parameter int unsigned DW      = 32,
   parameter int unsigned MODE_W  = 3,
   parameter int unsigned HGT_W   = 10,
   parameter bit          VB_SYNC = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [CSR_AW-1:0] bus_addr,
   input  logic [DW-1:0]     bus_wdata,
   input  logic [CSR_AW-1:0] rd_addr,
   output logic [DW-1:0]     rd_data,
   input  logic              vblank,
   output logic [DW-1:0]     act_ctrl,
   output logic [DW-1:0]     act_pos,
   output logic [DW-1:0]     act_base,
   output logic [DW-1:0]     act_phgt,
   output logic              plane_on,
   output logic              armed
);
   generate
      if (MODE_W < 1 || MODE_W > DW) begin : g_bad_mode
         $error("MODE_W must lie in 1..DW");
      end
      if (HGT_W + 1 >= DW) begin : g_bad_hgt
         $error("HGT_W must leave room for the enable bit");
      end
      if ((1 << CSR_AW) != NUM_CSR) begin : g_bad_map
         $error("address width does not match register count");
      end
   endgenerate

   logic [NUM_CSR-1:0]         pend_ld;
   logic [NUM_CSR-1:0][DW-1:0] pend_din, pend_q;
   logic [NUM_CSR-1:0][DW-1:0] act_q;
   logic                       xfer, live;

   always_comb begin
      for (int i = 0; i < NUM_CSR; i++) begin
         pend_ld[i]  = bus_wr && (bus_addr == CSR_AW'(i));
         pend_din[i] = bus_wdata;
      end
   end

   curs_regbank #(.DW(DW), .HGT_W(HGT_W)) u_pend (
      .clk(clk), .rst_n(rst_n), .ld(pend_ld), .din(pend_din), .q(pend_q)
   );

   curs_regbank #(.DW(DW), .HGT_W(HGT_W)) u_act (
      .clk(clk), .rst_n(rst_n), .ld({NUM_CSR{xfer}}), .din(pend_q), .q(act_q)
   );

   assign live = |act_q[CSR_CTRL][MODE_W-1:0];

   curs_armctl #(.MODE_W(MODE_W), .VB_SYNC(VB_SYNC)) u_arm (
      .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr),
      .wr_mode(bus_wdata[MODE_W-1:0]), .act_live(live), .vblank(vblank),
      .armed(armed), .xfer(xfer)
   );

   assign rd_data  = pend_q[rd_addr];
   assign act_ctrl = act_q[CSR_CTRL];
   assign act_pos  = act_q[CSR_POS];
   assign act_base = act_q[CSR_BASE];
   assign act_phgt = act_q[CSR_PHGT];
   assign plane_on = live;
endmodule

// File: rtl/curs_shadow_chk.sv
module curs_shadow_chk #(
   parameter int unsigned DW      = 32,
   parameter int unsigned MODE_W  = 3,
   parameter bit          VB_SYNC = 1'b0
) (
   input logic          clk,
   input logic          rst_n,
   input logic          bus_wr,
   input logic [1:0]    bus_addr,
   input logic [DW-1:0] bus_wdata,
   input logic          vblank,
   input logic [DW-1:0] act_ctrl,
   input logic [DW-1:0] act_pos,
   input logic [DW-1:0] act_base,
   input logic [DW-1:0] act_phgt,
   input logic          plane_on,
   input logic          armed
);
   logic vb_prev;
   always_ff @(posedge clk) begin
      if (!rst_n) vb_prev <= 1'b0;
      else        vb_prev <= vblank;
   end
   wire vb_up = vblank & ~vb_prev;
   wire en_wr = bus_wr && bus_addr == 2'd0 && (|bus_wdata[MODE_W-1:0]) && !plane_on;

   a_r3_base_arms: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == 2'd2) |=> armed);

   a_r8_pos_no_arm: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == 2'd1 && !armed) |=> !armed);

   a_r6_write_cancels: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr != 2'd2 && !en_wr) |=> !armed);

   a_r7_enable_arms: assert property (@(posedge clk) disable iff (!rst_n)
      en_wr |=> armed);

   generate
      if (!VB_SYNC) begin : g_edge
         a_r4_xfer_clears: assert property (@(posedge clk) disable iff (!rst_n)
            (vb_up && armed && !bus_wr) |=> !armed);

         a_r5_hold_unarmed: assert property (@(posedge clk) disable iff (!rst_n)
            !(vb_up && armed) |=> ($stable(act_ctrl) && $stable(act_pos) &&
                                   $stable(act_base) && $stable(act_phgt)));
      end
   endgenerate
endmodule

bind curs_shadow curs_shadow_chk #(.DW(DW), .MODE_W(MODE_W), .VB_SYNC(VB_SYNC)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
   .bus_wdata(bus_wdata), .vblank(vblank), .act_ctrl(act_ctrl),
   .act_pos(act_pos), .act_base(act_base), .act_phgt(act_phgt),
   .plane_on(plane_on), .armed(armed)
);

// File: tb/curs_shadow_bench.sv
`timescale 1ns/1ps
module curs_shadow_bench;
   localparam logic [31:0] PH_MASK = 32'h8000_03FF;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [1:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [1:0]  rd_addr = '0;
   logic [31:0] rd_data;
   logic        vblank = 1'b0;
   logic [31:0] act_ctrl, act_pos, act_base, act_phgt;
   logic        plane_on, armed;

   int unsigned n_vec = 0;
   int unsigned n_bad = 0;
   bit          done  = 1'b0;

   logic [31:0] m_pend [4];
   logic [31:0] m_act  [4];
   bit          m_armed;
   bit          m_vbq;

   always #2.5 clk = ~clk;

   curs_shadow u_curs_shadow (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .rd_addr(rd_addr), .rd_data(rd_data),
      .vblank(vblank), .act_ctrl(act_ctrl), .act_pos(act_pos),
      .act_base(act_base), .act_phgt(act_phgt), .plane_on(plane_on),
      .armed(armed)
   );

   function automatic logic [31:0] store_mask(input logic [1:0] a, input logic [31:0] d);
      return (a == 2'd3) ? (d & PH_MASK) : d;
   endfunction

   task automatic model_reset();
      for (int i = 0; i < 4; i++) begin
         m_pend[i] = '0;
         m_act[i]  = '0;
      end
      m_armed = 1'b0;
      m_vbq   = 1'b0;
   endtask

   // next state of the reference at one clock edge (R3..R8, R11)
   task automatic model_edge(input bit wr, input logic [1:0] a, input logic [31:0] d, input bit vb);
      bit rise, xf, arm, was_on;
      rise   = vb && !m_vbq;
      xf     = rise && m_armed;
      was_on = (m_act[0][2:0] != 3'd0);
      arm    = wr && (a == 2'd2 || (a == 2'd0 && d[2:0] != 3'd0 && !was_on));
      if (xf) for (int i = 0; i < 4; i++) m_act[i] = m_pend[i];
      if (arm)     m_armed = 1'b1;
      else if (wr) m_armed = 1'b0;
      else if (xf) m_armed = 1'b0;
      if (wr) m_pend[a] = store_mask(a, d);
      m_vbq = vb;
   endtask

   task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
      end
   endtask

   task automatic compare_all(input string tag, input logic [1:0] ra);
      chk(tag, "armed", {31'd0, armed}, {31'd0, m_armed});
      chk("R10", "plane_on", {31'd0, plane_on}, {31'd0, (m_act[0][2:0] != 3'd0)});
      chk(tag, "act_ctrl", act_ctrl, m_act[0]);
      chk(tag, "act_pos",  act_pos,  m_act[1]);
      chk(tag, "act_base", act_base, m_act[2]);
      chk(tag, "act_phgt", act_phgt, m_act[3]);
      chk(tag, "rd_data",  rd_data,  m_pend[ra]);
   endtask

   task automatic step(input bit wr, input logic [1:0] a, input logic [31:0] d,
                       input bit vb, input logic [1:0] ra, input string tag);
      @(negedge clk);
      bus_wr = wr; bus_addr = a; bus_wdata = d; vblank = vb; rd_addr = ra;
      @(posedge clk);
      model_edge(wr, a, d, vb);
      #1;
      compare_all(tag, ra);
   endtask

   initial begin
      #(5.0 * 150000);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      model_reset();
      repeat (4) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      for (int r = 0; r < 4; r++) begin
         rd_addr = r[1:0];
         #0.2;
         compare_all("R1", r[1:0]);
      end

      // R2 / R8: position alone neither shows nor arms
      step(1, 2'd1, 32'h0012_0034, 0, 2'd1, "R2");
      step(0, 2'd0, 32'h0,         0, 2'd1, "R8");
      chk("R8", "armed after pos", {31'd0, armed}, 32'd0);
      // R5: vblank with nothing armed
      step(0, 2'd0, 32'h0, 1, 2'd1, "R5");
      step(0, 2'd0, 32'h0, 1, 2'd1, "R5");
      chk("R5", "act_pos unarmed", act_pos, 32'h0);
      step(0, 2'd0, 32'h0, 0, 2'd1, "R5");
      // R9: partial height field masking
      step(1, 2'd3, 32'hFFFF_FFFF, 0, 2'd3, "R9");
      chk("R9", "phgt readback", rd_data, 32'h8000_03FF);
      // R3: base arms
      step(1, 2'd2, 32'hABCD_0000, 0, 2'd2, "R3");
      chk("R3", "armed", {31'd0, armed}, 32'd1);
      // R4: transfer on rising vblank
      step(0, 2'd0, 32'h0, 1, 2'd0, "R4");
      chk("R4", "act_base", act_base, 32'hABCD_0000);
      chk("R4", "act_pos",  act_pos,  32'h0012_0034);
      chk("R4", "armed cleared", {31'd0, armed}, 32'd0);
      // R5: vblank held high, re-arm: no transfer until a new rise
      step(1, 2'd2, 32'h1111_0000, 1, 2'd2, "R5");
      step(0, 2'd0, 32'h0,         1, 2'd2, "R5");
      chk("R5", "held vblank no xfer", act_base, 32'hABCD_0000);
      step(0, 2'd0, 32'h0, 0, 2'd2, "R5");
      step(0, 2'd0, 32'h0, 1, 2'd2, "R5");
      chk("R5", "xfer on new rise", act_base, 32'h1111_0000);
      step(0, 2'd0, 32'h0, 0, 2'd2, "R5");
      // R6: arm, then position write cancels
      step(1, 2'd2, 32'h2222_0000, 0, 2'd2, "R6");
      step(1, 2'd1, 32'h0000_0077, 0, 2'd1, "R6");
      chk("R6", "armed cancelled", {31'd0, armed}, 32'd0);
      step(0, 2'd0, 32'h0, 1, 2'd2, "R6");
      chk("R6", "no xfer after cancel", act_base, 32'h1111_0000);
      step(0, 2'd0, 32'h0, 0, 2'd2, "R6");
      // R7: enable write with plane off arms
      step(1, 2'd0, 32'h0000_0003, 0, 2'd0, "R7");
      chk("R7", "enable arms", {31'd0, armed}, 32'd1);
      step(0, 2'd0, 32'h0, 1, 2'd0, "R7");
      chk("R10", "plane_on", {31'd0, plane_on}, 32'd1);
      step(0, 2'd0, 32'h0, 0, 2'd0, "R7");
      // R7: control write with plane on does not arm, and cancels
      step(1, 2'd2, 32'h3333_0000, 0, 2'd2, "R7");
      step(1, 2'd0, 32'h0000_0005, 0, 2'd0, "R7");
      chk("R7", "ctrl while on cancels", {31'd0, armed}, 32'd0);
      // R11: write on the transfer edge
      step(1, 2'd2, 32'h4444_0000, 0, 2'd2, "R11");
      step(1, 2'd2, 32'h5555_0000, 1, 2'd2, "R11");
      chk("R11", "pre-write value moved", act_base, 32'h4444_0000);
      chk("R11", "arm wins on edge", {31'd0, armed}, 32'd1);
      step(0, 2'd0, 32'h0, 0, 2'd2, "R11");
      step(1, 2'd1, 32'h0000_0099, 1, 2'd1, "R11");
      chk("R11", "cancel on edge", {31'd0, armed}, 32'd0);
      chk("R11", "xfer still taken", act_base, 32'h5555_0000);
      step(0, 2'd0, 32'h0, 0, 2'd1, "R11");

      // seeded random traffic checked against the model
      for (int k = 0; k < 3000; k++) begin
         bit          w;
         logic [1:0]  a;
         logic [31:0] d;
         bit          v;
         w = ($urandom % 3) != 0;
         a = 2'($urandom % 4);
         d = $urandom;
         if (a == 2'd0 && ($urandom % 2) == 0) d[2:0] = 3'd0;
         v = ($urandom % 4) == 0;
         step(w, a, d, v, 2'($urandom % 4), "R2");
      end

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule